// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority Voting and Noise Count

This block recovers serial characters from a single input line. In its asynchronous mode, the clock is the oversampling clock. A sample enable marks which cycles count as sample ticks. The line is sampled at 8, 16 or 32 ticks per bit. Each bit is decided by a majority vote over three consecutive samples taken at the middle of the bit. When the three samples of a bit disagree, that is noted as noise and counted in a saturating counter.

A character is a low start bit, then 5 to 8 data bits sent least significant first. An address bit and a parity bit may follow, each optional, and then the stop bit. When a character completes, the block pulses a valid strobe for one cycle. It shows only the data field on the byte output. The address bit, parity error, framing error and noise flags come out on separate status pins. The receiver returns to idle as soon as the stop bit has been voted, so the stop bit may be shorter than a full bit.

In synchronous mode, each enabled cycle is one 1x data clock edge. The line is sampled once per bit with no voting. The same character format is used.

Top module: `osr_uart_rx`

## Requirements
- R1: After reset, `valid_o` is 0, `noise_cnt_o` is 0 and `data_o` is 0.
- R2: `osr_sel_i` selects the ticks per bit: 2'b00 gives 8, 2'b01 gives 16, and 2'b10 or 2'b11 gives 32.
- R3: In asynchronous mode, the tick on which an idle receiver first samples the line low is phase 0 of the start bit. Every bit is N ticks long. Each bit's value is the majority of the samples at phases N/2-1, N/2 and N/2+1 of that bit, so a single flipped sample does not change the value.
- R4: Each voted bit whose three samples disagree adds one to `noise_cnt_o`. This includes the start bit of a false start. `noise_o` is 1 with a character if any of its bits disagreed.
- R5: `noise_cnt_o` saturates at 2^NOISE_W-1 and never wraps.
- R6: `len_i` gives the data bit count minus 5 (0 = 5 bits, 3 = 8 bits). The first data bit lands in `data_o[0]`, and the bits of `data_o` above the data field read 0.
- R7: When `addr_en_i` is 1, the bit after the data field is reported on `addr_o`. When `addr_en_i` is 0, `addr_o` reads 0.
- R8: When `par_en_i` is 1, a parity bit follows the address bit, or the data if there is no address bit. Parity covers the data bits and the address bit. A mismatch sets `par_err_o`: with `par_odd_i`=0 the total count of ones including parity must be even, and with `par_odd_i`=1 it must be odd. When `par_en_i` is 0, `par_err_o` reads 0.
- R9: If the start bit votes high, the receiver returns to idle and produces no character.
- R10: A stop bit that votes low sets `frm_err_o`, and the character is still delivered.
- R11: `valid_o` is a one-cycle pulse in the cycle after the tick that votes the stop bit (phase N/2+1). The next tick may already begin a new start bit.
- R12: In synchronous mode, a low sample on an idle enabled cycle is the start bit. Each following enabled cycle is one bit, and cycles with `samp_en_i` low are ignored. `noise_o` stays 0 and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (the oversampling clock in asynchronous mode) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial line, already synchronous to clk_i, idles high |
| samp_en_i | input | 1 | Sample tick qualifier (1x data clock edge in synchronous mode) |
| sync_mode_i | input | 1 | 1 selects synchronous 1x sampling |
| osr_sel_i | input | 2 | Ticks per bit: 00=8, 01=16, 1x=32 |
| len_i | input | LEN_W | Data bit count minus 5 |
| addr_en_i | input | 1 | Address bit present |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| valid_o | output | 1 | One-cycle strobe: a character has completed |
| data_o | output | DATA_W | Data field, first received bit in bit 0 |
| addr_o | output | 1 | Received address bit |
| par_err_o | output | 1 | Parity mismatch |
| frm_err_o | output | 1 | Stop bit voted low |
| noise_o | output | 1 | Some bit of this character had disagreeing samples |
| noise_cnt_o | output | NOISE_W | Saturating count of noisy bits |

## Verification
The hardest situations to reach from the ports are a noisy false start and counter saturation. A noisy false start needs the line low for exactly N/2 ticks, so that one centre sample is low and two are high. Saturation needs many disagreeing bits. The stimulus therefore drives the line tick by tick and flips the single sample at phase N/2 of chosen bits. It uses a 3-bit counter so that one fully glitched 32x character pushes the count to its ceiling. Back-to-back characters whose stop bit lasts only N/2+2 ticks test that the very next tick is taken as a start.

// File: rtl/osr_uart_rx_pkg.sv
package osr_uart_rx_pkg;

   localparam int unsigned OSR_TOP  = 32;
   localparam int unsigned PH_W     = $clog2(OSR_TOP);
   localparam int unsigned MIN_BITS = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_ADDR,
      ST_PAR,
      ST_STOP
   } rx_st_e;

   // half of the ticks per bit, centre of a bit
   function automatic logic [PH_W-1:0] half_of(input logic [1:0] sel);
      logic [PH_W-1:0] h;
      case (sel)
         2'b00:   h = PH_W'(4);
         2'b01:   h = PH_W'(8);
         default: h = PH_W'(16);
      endcase
      return h;
   endfunction

endpackage

// File: rtl/osr_uart_rx_timer.sv
module osr_uart_rx_timer
   import osr_uart_rx_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       samp_en_i,
   input  logic       sync_mode_i,
   input  logic [1:0] osr_sel_i,
   input  logic       busy_i,
   input  logic       launch_i,
   output logic       tap_a_o,
   output logic       tap_b_o,
   output logic       bit_evt_o
);

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] half;
   logic [PH_W:0]   span;
   logic [PH_W:0]   last_w;
   logic            os_tick;

   always_comb begin
      half    = half_of(osr_sel_i);
      span    = {half, 1'b0};
      last_w  = span - 1'b1;
      os_tick = samp_en_i && busy_i && !sync_mode_i;
   end

   // phase 0 is the tick that saw the falling edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else if (launch_i) begin
         phase_q <= PH_W'(1);
      end else if (os_tick) begin
         if (phase_q == last_w[PH_W-1:0]) phase_q <= '0;
         else                              phase_q <= phase_q + 1'b1;
      end
   end

   assign tap_a_o   = os_tick && (phase_q == half - 1'b1);
   assign tap_b_o   = os_tick && (phase_q == half);
   assign bit_evt_o = samp_en_i && busy_i &&
                      (sync_mode_i || (phase_q == half + 1'b1));

endmodule

// File: rtl/osr_uart_rx_vote.sv
module osr_uart_rx_vote (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   input  logic sync_mode_i,
   input  logic tap_a_i,
   input  logic tap_b_i,
   output logic bit_val_o,
   output logic bit_noisy_o
);

   logic s_a_q;
   logic s_b_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s_a_q <= 1'b1;
         s_b_q <= 1'b1;
      end else begin
         if (tap_a_i) s_a_q <= line_i;
         if (tap_b_i) s_b_q <= line_i;
      end
   end

   // third sample is the live line at the deciding tick
   always_comb begin
      if (sync_mode_i) begin
         bit_val_o   = line_i;
         bit_noisy_o = 1'b0;
      end else begin
         bit_val_o   = (s_a_q & s_b_q) | (s_a_q & line_i) | (s_b_q & line_i);
         bit_noisy_o = !((s_a_q == s_b_q) && (s_b_q == line_i));
      end
   end

endmodule

// File: rtl/osr_uart_rx_noise.sv
module osr_uart_rx_noise #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         cnt_o <= '0;
      else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
   end

endmodule

// File: rtl/osr_uart_rx_frame.sv
module osr_uart_rx_frame
   import osr_uart_rx_pkg::*;
#(
   parameter  int unsigned DATA_W = 8,
   localparam int unsigned LEN_W  = $clog2(DATA_W - 4),
   localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_i,
   input  logic              samp_en_i,
   input  logic              sync_mode_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic              addr_en_i,
   input  logic              par_en_i,
   input  logic              par_odd_i,
   input  logic              bit_evt_i,
   input  logic              bit_val_i,
   input  logic              bit_noisy_i,
   output logic              busy_o,
   output logic              launch_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic              addr_o,
   output logic              par_err_o,
   output logic              frm_err_o,
   output logic              noise_o
);

   rx_st_e              st_q;
   logic [IDX_W-1:0]    bit_idx_q;
   logic [IDX_W-1:0]    last_idx;
   logic                addr_q;
   logic                par_acc_q;
   logic                perr_q;
   logic                noisy_q;
   logic [DATA_W-1:0]   shift_w;

   assign last_idx = IDX_W'(len_i) + IDX_W'(MIN_BITS - 1);
   assign busy_o   = (st_q != ST_IDLE);
   assign launch_o = (st_q == ST_IDLE) && samp_en_i && !line_i;

   for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            q <= 1'b0;
         else if (launch_o)
            q <= 1'b0;
         else if (st_q == ST_DATA && bit_evt_i && bit_idx_q == IDX_W'(gi))
            q <= bit_val_i;
      end
      assign shift_w[gi] = q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         bit_idx_q <= '0;
         addr_q    <= 1'b0;
         par_acc_q <= 1'b0;
         perr_q    <= 1'b0;
         noisy_q   <= 1'b0;
         valid_o   <= 1'b0;
         data_o    <= '0;
         addr_o    <= 1'b0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
         noise_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (launch_o) begin
                  st_q      <= sync_mode_i ? ST_DATA : ST_START;
                  bit_idx_q <= '0;
                  addr_q    <= 1'b0;
                  par_acc_q <= 1'b0;
                  perr_q    <= 1'b0;
                  noisy_q   <= 1'b0;
               end
            end
            ST_START: begin
               if (bit_evt_i) begin
                  noisy_q <= bit_noisy_i;
                  st_q    <= bit_val_i ? ST_IDLE : ST_DATA;
               end
            end
            ST_DATA: begin
               if (bit_evt_i) begin
                  noisy_q   <= noisy_q | bit_noisy_i;
                  par_acc_q <= par_acc_q ^ bit_val_i;
                  if (bit_idx_q == last_idx) begin
                     if (addr_en_i)     st_q <= ST_ADDR;
                     else if (par_en_i) st_q <= ST_PAR;
                     else               st_q <= ST_STOP;
                  end else begin
                     bit_idx_q <= bit_idx_q + 1'b1;
                  end
               end
            end
            ST_ADDR: begin
               if (bit_evt_i) begin
                  noisy_q   <= noisy_q | bit_noisy_i;
                  addr_q    <= bit_val_i;
                  par_acc_q <= par_acc_q ^ bit_val_i;
                  st_q      <= par_en_i ? ST_PAR : ST_STOP;
               end
            end
            ST_PAR: begin
               if (bit_evt_i) begin
                  noisy_q <= noisy_q | bit_noisy_i;
                  perr_q  <= par_acc_q ^ bit_val_i ^ par_odd_i;
                  st_q    <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (bit_evt_i) begin
                  valid_o   <= 1'b1;
                  data_o    <= shift_w;
                  addr_o    <= addr_q;
                  par_err_o <= perr_q;
                  frm_err_o <= !bit_val_i;
                  noise_o   <= noisy_q | bit_noisy_i;
                  st_q      <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx #(
   parameter  int unsigned DATA_W  = 8,
   parameter  int unsigned NOISE_W = 16,
   localparam int unsigned LEN_W   = $clog2(DATA_W - 4)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               line_i,
   input  logic               samp_en_i,
   input  logic               sync_mode_i,
   input  logic [1:0]         osr_sel_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic               addr_en_i,
   input  logic               par_en_i,
   input  logic               par_odd_i,
   output logic               valid_o,
   output logic [DATA_W-1:0]  data_o,
   output logic               addr_o,
   output logic               par_err_o,
   output logic               frm_err_o,
   output logic               noise_o,
   output logic [NOISE_W-1:0] noise_cnt_o
);

   if (DATA_W < 6 || DATA_W > 16) begin : g_bad_data_w
      $error("osr_uart_rx: DATA_W must lie in 6..16");
   end
   if (NOISE_W < 1) begin : g_bad_noise_w
      $error("osr_uart_rx: NOISE_W must be at least 1");
   end

   logic busy;
   logic launch;
   logic tap_a;
   logic tap_b;
   logic bit_evt;
   logic bit_val;
   logic bit_noisy;

   osr_uart_rx_timer u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .samp_en_i   (samp_en_i),
      .sync_mode_i (sync_mode_i),
      .osr_sel_i   (osr_sel_i),
      .busy_i      (busy),
      .launch_i    (launch),
      .tap_a_o     (tap_a),
      .tap_b_o     (tap_b),
      .bit_evt_o   (bit_evt)
   );

   osr_uart_rx_vote u_vote (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_i      (line_i),
      .sync_mode_i (sync_mode_i),
      .tap_a_i     (tap_a),
      .tap_b_i     (tap_b),
      .bit_val_o   (bit_val),
      .bit_noisy_o (bit_noisy)
   );

   osr_uart_rx_frame #(.DATA_W(DATA_W)) u_frame (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .line_i      (line_i),
      .samp_en_i   (samp_en_i),
      .sync_mode_i (sync_mode_i),
      .len_i       (len_i),
      .addr_en_i   (addr_en_i),
      .par_en_i    (par_en_i),
      .par_odd_i   (par_odd_i),
      .bit_evt_i   (bit_evt),
      .bit_val_i   (bit_val),
      .bit_noisy_i (bit_noisy),
      .busy_o      (busy),
      .launch_o    (launch),
      .valid_o     (valid_o),
      .data_o      (data_o),
      .addr_o      (addr_o),
      .par_err_o   (par_err_o),
      .frm_err_o   (frm_err_o),
      .noise_o     (noise_o)
   );

   osr_uart_rx_noise #(.W(NOISE_W)) u_noise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (bit_evt && bit_noisy),
      .cnt_o  (noise_cnt_o)
   );

endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
   parameter  int unsigned DATA_W  = 8,
   parameter  int unsigned NOISE_W = 16,
   localparam int unsigned LEN_W   = $clog2(DATA_W - 4)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               samp_en_i,
   input logic               sync_mode_i,
   input logic [LEN_W-1:0]   len_i,
   input logic               addr_en_i,
   input logic               par_en_i,
   input logic               valid_o,
   input logic [DATA_W-1:0]  data_o,
   input logic               addr_o,
   input logic               par_err_o,
   input logic               noise_o,
   input logic [NOISE_W-1:0] noise_cnt_o
);

   localparam logic [NOISE_W-1:0] CNT_MAX = '1;

   p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (noise_cnt_o == $past(noise_cnt_o) ||
                noise_cnt_o == $past(noise_cnt_o) + 1'b1));

   p_cnt_hold_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (noise_cnt_o == CNT_MAX) |=> (noise_cnt_o == CNT_MAX));

   p_data_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ((data_o >> (32'(len_i) + 5)) == '0));

   p_addr_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !addr_en_i) |-> !addr_o);

   p_par_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !par_en_i) |-> !par_err_o);

   p_valid_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);

   p_no_tick_no_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !samp_en_i |=> !valid_o);

   p_sync_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_mode_i && valid_o) |-> !noise_o);

endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DATA_W(DATA_W), .NOISE_W(NOISE_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .samp_en_i   (samp_en_i),
   .sync_mode_i (sync_mode_i),
   .len_i       (len_i),
   .addr_en_i   (addr_en_i),
   .par_en_i    (par_en_i),
   .valid_o     (valid_o),
   .data_o      (data_o),
   .addr_o      (addr_o),
   .par_err_o   (par_err_o),
   .noise_o     (noise_o),
   .noise_cnt_o (noise_cnt_o)
);

// File: tb/osr_uart_rx_bench.sv
module osr_uart_rx_bench;

   localparam int DW      = 8;
   localparam int NW      = 3;
   localparam int CNT_TOP = 7;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          line;
   logic          samp_en;
   logic          sync_mode;
   logic [1:0]    osr;
   logic [1:0]    len;
   logic          addr_en, par_en, par_odd;
   logic          valid_o, addr_o, par_err_o, frm_err_o, noise_o;
   logic [DW-1:0] data_o;
   logic [NW-1:0] noise_cnt_o;

   always #5 clk = ~clk;

   osr_uart_rx #(.DATA_W(DW), .NOISE_W(NW)) u_osr_uart_rx (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .line_i      (line),
      .samp_en_i   (samp_en),
      .sync_mode_i (sync_mode),
      .osr_sel_i   (osr),
      .len_i       (len),
      .addr_en_i   (addr_en),
      .par_en_i    (par_en),
      .par_odd_i   (par_odd),
      .valid_o     (valid_o),
      .data_o      (data_o),
      .addr_o      (addr_o),
      .par_err_o   (par_err_o),
      .frm_err_o   (frm_err_o),
      .noise_o     (noise_o),
      .noise_cnt_o (noise_cnt_o)
   );

   typedef struct {
      int          at;
      logic [7:0]  d;
      logic        a, pe, fe, nz;
      int          cnt;
      string       tag;
   } exp_t;

   exp_t  q[$];
   exp_t  cur;
   int    cyc     = 0;
   int    n_chk   = 0;
   int    n_fail  = 0;
   int    exp_cnt = 0;
   bit    chk_on  = 1'b0;
   bit    done    = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // per-cycle comparison against the expected character schedule
   always @(negedge clk) begin
      if (chk_on) begin
         if (q.size() > 0 && q[0].at < cyc) begin
            n_chk++; n_fail++;
            $display("FAIL %s R11: valid missing at cycle %0d, actual 0 expected 1", q[0].tag, q[0].at);
            void'(q.pop_front());
         end
         if (q.size() > 0 && q[0].at == cyc) begin
            cur = q.pop_front();
            n_chk++;
            if (valid_o !== 1'b1 || data_o !== cur.d || addr_o !== cur.a ||
                par_err_o !== cur.pe || frm_err_o !== cur.fe || noise_o !== cur.nz ||
                int'(noise_cnt_o) != cur.cnt) begin
               n_fail++;
               $display("FAIL %s: actual v=%b d=%h a=%b pe=%b fe=%b nz=%b cnt=%0d expected v=1 d=%h a=%b pe=%b fe=%b nz=%b cnt=%0d",
                        cur.tag, valid_o, data_o, addr_o, par_err_o, frm_err_o, noise_o, noise_cnt_o,
                        cur.d, cur.a, cur.pe, cur.fe, cur.nz, cur.cnt);
            end
         end else if (valid_o) begin
            n_chk++; n_fail++;
            $display("FAIL R11/R9: unexpected valid at cycle %0d, actual 1 expected 0", cyc);
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         line = 1'b1;
      end
   endtask

   task automatic low_pulse(input int n);
      repeat (n) begin
         @(negedge clk);
         line = 1'b0;
      end
   endtask

   // gmask bit k flips the centre sample of frame bit k (bit 0 = start)
   task automatic send_frame(input logic [7:0] d, input logic a, input logic pinj,
                             input logic stop_v, input int stop_len, input int gmask,
                             input string tag);
      logic b[$];
      int   nb = int'(len) + 5;
      int   n  = 8 << ((osr == 2'b00) ? 0 : (osr == 2'b01) ? 1 : 2);
      int   ng = 0;
      logic par = 1'b0;
      exp_t e;
      b.push_back(1'b0);
      for (int i = 0; i < nb; i++) begin
         b.push_back(d[i]);
         par = par ^ d[i];
      end
      if (addr_en) begin
         b.push_back(a);
         par = par ^ a;
      end
      if (par_en) b.push_back(par ^ par_odd ^ pinj);
      b.push_back(stop_v);
      for (int k = 0; k < b.size(); k++) if (gmask[k]) ng++;
      e.d   = d & 8'((1 << nb) - 1);
      e.a   = addr_en ? a : 1'b0;
      e.pe  = par_en ? pinj : 1'b0;
      e.fe  = !stop_v;
      e.nz  = (ng > 0);
      exp_cnt = (exp_cnt + ng > CNT_TOP) ? CNT_TOP : exp_cnt + ng;
      e.cnt = exp_cnt;
      e.tag = tag;
      e.at  = 0;
      for (int k = 0; k < b.size(); k++) begin
         bit last = (k == b.size() - 1);
         if (sync_mode) begin
            @(negedge clk);
            line    = b[k];
            samp_en = 1'b1;
            if (last) begin
               e.at = cyc + 1;
               q.push_back(e);
            end
            @(negedge clk);
            samp_en = 1'b0;
            repeat (2) @(negedge clk);
         end else begin
            int blen = last ? stop_len : n;
            for (int p = 0; p < blen; p++) begin
               @(negedge clk);
               line = (gmask[k] && p == n / 2) ? ~b[k] : b[k];
               if (last && p == n / 2 + 1) begin
                  e.at = cyc + 1;
                  q.push_back(e);
               end
            end
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; line = 1'b1; samp_en = 1'b1; sync_mode = 1'b0;
      osr = 2'b00; len = 2'd3; addr_en = 1'b0; par_en = 1'b0; par_odd = 1'b0;
      repeat (4) @(negedge clk);
      check(valid_o === 1'b0, "R1", "valid after reset", int'(valid_o), 0);
      check(noise_cnt_o === '0, "R1", "noise count after reset", int'(noise_cnt_o), 0);
      check(data_o === '0, "R1", "data after reset", int'(data_o), 0);
      rst_n = 1'b1;
      chk_on = 1'b1;
      idle(20);

      // R2 8x, R3 R6 clean 8-bit characters
      send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 8, 0, "R2 R3 R6 8x");
      idle(10);
      // R11 short stop bit, next start on the very next tick
      send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 6, 0, "R11 short stop");
      send_frame(8'h81, 1'b0, 1'b0, 1'b1, 8, 0, "R11 early start");
      idle(10);
      // R3 R4 glitch on data bit 2 does not change the value
      send_frame(8'h5A, 1'b0, 1'b0, 1'b1, 8, 1 << 3, "R3 R4 glitch");
      idle(10);
      // R9 false starts
      low_pulse(2);
      idle(30);
      check(int'(noise_cnt_o) == exp_cnt, "R9", "count after clean false start", int'(noise_cnt_o), exp_cnt);
      low_pulse(4);
      idle(30);
      exp_cnt++;
      check(int'(noise_cnt_o) == exp_cnt, "R4 R9", "count after noisy false start", int'(noise_cnt_o), exp_cnt);
      send_frame(8'h0F, 1'b0, 1'b0, 1'b1, 8, 1, "R4 start glitch");
      idle(10);

      // 16x, 5-bit data with address and parity
      osr = 2'b01; len = 2'd0; addr_en = 1'b1; par_en = 1'b1; par_odd = 1'b0;
      idle(4);
      send_frame(8'h16, 1'b1, 1'b0, 1'b1, 16, 0, "R2 R7 R8 even ok");
      idle(10);
      send_frame(8'h09, 1'b0, 1'b1, 1'b1, 16, 0, "R8 even error");
      idle(10);
      par_odd = 1'b1;
      idle(2);
      send_frame(8'h1B, 1'b1, 1'b0, 1'b1, 16, 0, "R8 odd ok");
      idle(10);
      send_frame(8'hFF, 1'b0, 1'b1, 1'b1, 16, 0, "R6 R8 odd error mask");
      idle(10);

      // 32x, 7-bit data, odd parity, no address: saturation and framing
      osr = 2'b10; len = 2'd2; addr_en = 1'b0;
      idle(4);
      send_frame(8'h55, 1'b0, 1'b0, 1'b1, 32, 32'h3FF, "R2 R5 saturate");
      idle(10);
      check(int'(noise_cnt_o) == CNT_TOP, "R5", "saturated count", int'(noise_cnt_o), CNT_TOP);
      send_frame(8'h2A, 1'b0, 1'b0, 1'b1, 32, 1 << 1, "R5 hold at max");
      idle(10);
      send_frame(8'h33, 1'b0, 1'b0, 1'b0, 18, 0, "R10 framing");
      idle(80);
      par_en = 1'b0;
      idle(2);
      send_frame(8'h4C, 1'b0, 1'b0, 1'b1, 32, 0, "R8 parity off");
      idle(10);

      // R12 synchronous 1x mode with gaps between ticks
      samp_en = 1'b0; sync_mode = 1'b1; len = 2'd3; addr_en = 1'b1;
      par_en = 1'b1; par_odd = 1'b0;
      idle(4);
      send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 1, 0, "R12 sync");
      idle(6);
      send_frame(8'h7E, 1'b1, 1'b1, 1'b1, 1, 0, "R12 sync parity error");
      idle(6);
      send_frame(8'h11, 1'b0, 1'b0, 1'b0, 1, 0, "R10 R12 sync framing");
      idle(12);
      check(int'(noise_cnt_o) == CNT_TOP, "R12", "count unchanged in sync", int'(noise_cnt_o), CNT_TOP);

      idle(20);
      check(q.size() == 0, "R11", "pending characters", q.size(), 0);
      chk_on = 1'b0;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule